// File: doc/BRIEF.md
# Fuse-Gated Code Protection Controller

This block sits between the program flash / data RAM and the two agents that may ask for access to them: the debug port and the CPU. Each cycle either agent may present one request (read, page erase, page write or bulk erase) with a page number. One cycle later the block answers with exactly one of grant or deny for that requester. Flash and RAM act only on a grant, so a denied request changes nothing in them. A granted bulk erase also produces a one-cycle pulse that clears the data RAM.

Access policy depends on three things. Two one-time fuse levels are captured once as reset is released and then hold until the next reset. The third is a protect bit that software sets through the flash control register. The protect bit is set-only and takes effect only when the mode-0 fuse is blown. Once it takes effect the controller is in the guarded mode. In that mode the debug port may only bulk-erase, and page 0 may not be page-erased or written by anyone. Only a reset leaves the guarded mode, and the expected recovery is a bulk erase followed by a reset. A blown mode-1 fuse shuts the debug port off for good. A status byte reports the captured mode-0 fuse and the live level of the security pin.

The controller FSM has three states:
- `ST_LATCH`: the first cycle out of reset. The fuses are captured here and the debug port is disabled.
- `ST_OPEN`: no protection is in effect.
- `ST_GUARD`: mode-0 protection is in effect.

It has four transitions:
- `ST_LATCH -> ST_OPEN` happens unconditionally, unless the next transition applies.
- `ST_LATCH -> ST_GUARD` happens when a protect write coincides with a blown mode-0 fuse.
- `ST_OPEN -> ST_GUARD` happens on a protect write while the captured mode-0 fuse is 1.
- `ST_GUARD -> ST_GUARD` holds until reset.

Top module: `code_guard`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, dbg_en is 0. While reset is asserted, every grant, deny and ram_clr output is 0.
- R2: fuse_m0 and fuse_m1 are captured on the first clock edge after reset release. Later changes on those inputs have no effect until the next reset. status bit 1 shows the captured mode-0 fuse.
- R3: A write (ctl_wr=1) with ctl_wdata bit 6 = 1 enters the guarded mode only when the captured mode-0 fuse is 1 (or, on the capture edge, when fuse_m0 is 1). A write with bit 6 = 0, or any write when the mode-0 fuse is 0, has no effect. Only reset leaves the guarded mode.
- R4: Operation codes are 0 read, 1 page erase, 2 page write, 3 bulk erase. In the guarded mode a debug request is granted only for code 3, and every other debug request is denied.
- R5: In the guarded mode a CPU page erase (1) or page write (2) to page 0 is denied. CPU requests to any other page, and CPU reads and bulk erases, are granted.
- R6: Outside the guarded mode, every CPU request is granted, and every debug request is granted while dbg_en is 1.
- R7: With the captured mode-1 fuse at 1, dbg_en is 0 and every debug request is denied, whatever the mode.
- R8: A request seen on a clock edge yields exactly one of grant or deny for that requester, high for the following cycle only. With no request, both are 0.
- R9: ram_clr is high for the cycle after an edge on which any bulk erase request was granted, and is 0 otherwise.
- R10: status bit 5 follows sec_pin combinationally, and all status bits other than 1 and 5 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Core reset, asynchronous, active low |
| ctl_wr | input | 1 | Write strobe for the flash control register |
| ctl_wdata | input | 8 | Write data; bit 6 is the protect bit |
| fuse_m0 | input | 1 | Mode-0 fuse level (1 = blown) |
| fuse_m1 | input | 1 | Mode-1 fuse level (1 = blown) |
| sec_pin | input | 1 | Security pin level |
| dbg_req | input | 1 | Debug-port request valid |
| dbg_op | input | 2 | Debug-port operation code |
| dbg_page | input | 8 | Debug-port page number |
| cpu_req | input | 1 | CPU request valid |
| cpu_op | input | 2 | CPU operation code |
| cpu_page | input | 8 | CPU page number |
| dbg_grant | output | 1 | Debug request granted |
| dbg_deny | output | 1 | Debug request denied |
| cpu_grant | output | 1 | CPU request granted |
| cpu_deny | output | 1 | CPU request denied |
| dbg_en | output | 1 | Debug port enabled |
| ram_clr | output | 1 | Data RAM clear pulse |
| status | output | 8 | Status byte: bit 1 captured mode-0 fuse, bit 5 sec_pin |

## Verification
The assertions check the cycle-local rules on every cycle:
- once guarded, the mode stays guarded;
- grant and deny are mutually exclusive, and each request gets exactly one answer;
- a non-bulk debug request and a page-0 erase or write by the CPU are denied while guarded;
- dbg_en stays low under a captured mode-1 fuse;
- captured fuses hold after the capture cycle.

Only the bench's scenarios show the following: a protect write is ignored without the fuse or with bit 6 clear, a reset leaves the guarded mode, and fuse changes after capture stay invisible through status and grants.

// File: rtl/cp_pkg.sv
package cp_pkg;
    typedef enum logic [1:0] {
        OP_READ     = 2'd0,
        OP_PG_ERASE = 2'd1,
        OP_PG_WRITE = 2'd2,
        OP_BULK     = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_LATCH = 2'd0,
        ST_OPEN  = 2'd1,
        ST_GUARD = 2'd2
    } mode_e;
endpackage

// File: rtl/cp_fuse_latch.sv
module cp_fuse_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic fuse_m0_i,
    input  logic fuse_m1_i,
    output logic m0_q,
    output logic m1_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m0_q <= 1'b0;
            m1_q <= 1'b0;
        end else if (capture) begin
            m0_q <= fuse_m0_i;
            m1_q <= fuse_m1_i;
        end
    end

    // R2
    fuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(m0_q) && $stable(m1_q)));
endmodule

// File: rtl/cp_mode_fsm.sv
module cp_mode_fsm
    import cp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  prot_set,
    input  logic  fuse_m0_raw,
    input  logic  m0_lat,
    output mode_e state,
    output logic  capture,
    output logic  guard
);
    mode_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LATCH;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LATCH: state_nx = (prot_set && fuse_m0_raw) ? ST_GUARD : ST_OPEN;
            ST_OPEN:  if (prot_set && m0_lat) state_nx = ST_GUARD;
            ST_GUARD: state_nx = ST_GUARD;
            default:  state_nx = ST_LATCH;
        endcase
    end

    always_comb begin
        capture = (state == ST_LATCH);
        guard   = (state == ST_GUARD);
    end

    // R3
    guard_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GUARD) |=> (state == ST_GUARD));
    // R1
    latch_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH) |=> (state != ST_LATCH));
endmodule

// File: rtl/cp_access_judge.sv
module cp_access_judge
    import cp_pkg::*;
#(
    parameter bit DEBUG_SIDE = 1'b0,
    parameter int PAGE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              allow,
    input  logic              guard,
    input  logic              req,
    input  logic [1:0]        op,
    input  logic [PAGE_W-1:0] page,
    output logic              grant,
    output logic              deny,
    output logic              bulk_done
);
    op_e  op_t;
    logic permit;

    assign op_t = op_e'(op);

    generate
        if (DEBUG_SIDE) begin : g_dbg
            assign permit = allow && (!guard || op_t == OP_BULK);
        end else begin : g_cpu
            logic page0_mod;
            assign page0_mod = (op_t == OP_PG_ERASE || op_t == OP_PG_WRITE)
                               && (page == '0);
            assign permit = allow && !(guard && page0_mod);

            // R5
            page0_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (guard && req && page == '0 && (op == 2'd1 || op == 2'd2)) |=> deny);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant     <= 1'b0;
            deny      <= 1'b0;
            bulk_done <= 1'b0;
        end else begin
            grant     <= req && permit;
            deny      <= req && !permit;
            bulk_done <= req && permit && (op_t == OP_BULK);
        end
    end

    // R8
    one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (grant != deny));
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!grant && !deny));
endmodule

// File: rtl/code_guard.sv
module code_guard
    import cp_pkg::*;
#(
    parameter int PAGE_W   = 8,
    parameter int CTL_W    = 8,
    parameter int PROT_BIT = 6,
    parameter int FUSE_BIT = 1,
    parameter int PIN_BIT  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              fuse_m0,
    input  logic              fuse_m1,
    input  logic              sec_pin,
    input  logic              dbg_req,
    input  logic [1:0]        dbg_op,
    input  logic [PAGE_W-1:0] dbg_page,
    input  logic              cpu_req,
    input  logic [1:0]        cpu_op,
    input  logic [PAGE_W-1:0] cpu_page,
    output logic              dbg_grant,
    output logic              dbg_deny,
    output logic              cpu_grant,
    output logic              cpu_deny,
    output logic              dbg_en,
    output logic              ram_clr,
    output logic [CTL_W-1:0]  status
);
    mode_e state;
    logic  capture, guard, m0_q, m1_q, dbg_bulk, cpu_bulk, prot_set;

    assign prot_set = ctl_wr && ctl_wdata[PROT_BIT];

    cp_fuse_latch u_fuse (
        .clk(clk), .rst_n(rst_n), .capture(capture),
        .fuse_m0_i(fuse_m0), .fuse_m1_i(fuse_m1),
        .m0_q(m0_q), .m1_q(m1_q)
    );

    cp_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .prot_set(prot_set),
        .fuse_m0_raw(fuse_m0), .m0_lat(m0_q),
        .state(state), .capture(capture), .guard(guard)
    );

    assign dbg_en = !capture && !m1_q;

    cp_access_judge #(.DEBUG_SIDE(1'b1), .PAGE_W(PAGE_W)) u_dbg (
        .clk(clk), .rst_n(rst_n), .allow(dbg_en), .guard(guard),
        .req(dbg_req), .op(dbg_op), .page(dbg_page),
        .grant(dbg_grant), .deny(dbg_deny), .bulk_done(dbg_bulk)
    );

    cp_access_judge #(.DEBUG_SIDE(1'b0), .PAGE_W(PAGE_W)) u_cpu (
        .clk(clk), .rst_n(rst_n), .allow(1'b1), .guard(guard),
        .req(cpu_req), .op(cpu_op), .page(cpu_page),
        .grant(cpu_grant), .deny(cpu_deny), .bulk_done(cpu_bulk)
    );

    assign ram_clr = dbg_bulk || cpu_bulk;

    always_comb begin
        status           = '0;
        status[FUSE_BIT] = m0_q;
        status[PIN_BIT]  = sec_pin;
    end

    // R4
    dbg_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (guard && dbg_req && dbg_op != 2'd3) |=> dbg_deny);
    // R7
    dbg_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m1_q |-> !dbg_en);
    // R9
    ram_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_clr |-> (dbg_grant || cpu_grant));
endmodule

// File: tb/code_guard_tb.sv
`timescale 1ns/1ps
module code_guard_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       fuse_m0 = 1'b0, fuse_m1 = 1'b0, sec_pin = 1'b0;
    logic       dbg_req = 1'b0, cpu_req = 1'b0;
    logic [1:0] dbg_op = '0, cpu_op = '0;
    logic [7:0] dbg_page = '0, cpu_page = '0;
    logic       dbg_grant, dbg_deny, cpu_grant, cpu_deny, dbg_en, ram_clr;
    logic [7:0] status;

    int checks = 0, fails = 0;
    int mstate = 0;
    bit em0 = 0, em1 = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    code_guard u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .fuse_m0(fuse_m0), .fuse_m1(fuse_m1), .sec_pin(sec_pin),
        .dbg_req(dbg_req), .dbg_op(dbg_op), .dbg_page(dbg_page),
        .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_page(cpu_page),
        .dbg_grant(dbg_grant), .dbg_deny(dbg_deny),
        .cpu_grant(cpu_grant), .cpu_deny(cpu_deny),
        .dbg_en(dbg_en), .ram_clr(ram_clr), .status(status)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit dbg_ok(int st, bit m1, logic [1:0] op);
        return (st != 0) && !m1 && (st != 2 || op == 2'd3);
    endfunction

    function automatic bit cpu_ok(int st, logic [1:0] op, logic [7:0] pg);
        return !(st == 2 && (op == 2'd1 || op == 2'd2) && pg == 8'd0);
    endfunction

    task automatic do_reset(input bit f0, input bit f1);
        @(negedge clk);
        rst_n = 1'b0; fuse_m0 = f0; fuse_m1 = f1;
        ctl_wr = 0; dbg_req = 0; cpu_req = 0;
        repeat (2) @(negedge clk);
        check("R1 dbg_en in reset", {7'd0, dbg_en}, 8'd0);
        check("R1 outputs in reset",
              {2'd0, dbg_grant, dbg_deny, cpu_grant, cpu_deny, ram_clr, 1'b0}, 8'd0);
        rst_n = 1'b1;
        mstate = 0;
        check("R1 dbg_en capture cycle", {7'd0, dbg_en}, 8'd0);
    endtask

    task automatic step(input bit cw, input logic [7:0] cwd,
                        input bit dv, input logic [1:0] dop, input logic [7:0] dpg,
                        input bit cv, input logic [1:0] cop, input logic [7:0] cpg,
                        input bit pin, input bit f0, input bit f1);
        bit eg_d, eg_c, pset;
        string dtag, ctag;
        ctl_wr = cw; ctl_wdata = cwd; dbg_req = dv; dbg_op = dop; dbg_page = dpg;
        cpu_req = cv; cpu_op = cop; cpu_page = cpg; sec_pin = pin;
        fuse_m0 = f0; fuse_m1 = f1;
        eg_d = dbg_ok(mstate, em1, dop);
        eg_c = cpu_ok(mstate, cop, cpg);
        dtag = (mstate == 0 || em1) ? "R7 dbg" : (mstate == 2 ? "R4 dbg" : "R6 dbg");
        ctag = (mstate == 2 && !eg_c) ? "R5 cpu" : "R6 cpu";
        pset = cw && cwd[6];
        @(posedge clk);
        if (mstate == 0) begin
            em0 = f0; em1 = f1;
            mstate = (pset && f0) ? 2 : 1;
        end else if (mstate == 1 && pset && em0) begin
            mstate = 2;
        end
        @(negedge clk);
        check({dtag, " grant"}, {7'd0, dbg_grant}, {7'd0, dv && eg_d});
        check("R8 dbg deny", {7'd0, dbg_deny}, {7'd0, dv && !eg_d});
        check({ctag, " grant"}, {7'd0, cpu_grant}, {7'd0, cv && eg_c});
        check("R8 cpu deny", {7'd0, cpu_deny}, {7'd0, cv && !eg_c});
        check("R9 ram_clr", {7'd0, ram_clr},
              {7'd0, (dv && eg_d && dop == 2'd3) || (cv && eg_c && cop == 2'd3)});
        check("R7 dbg_en", {7'd0, dbg_en}, {7'd0, mstate != 0 && !em1});
        check("R2 R10 status", status, {2'd0, sec_pin, 3'd0, em0, 1'b0});
    endtask

    task automatic idle(input bit f0, input bit f1);
        step(0, 8'h00, 0, 2'd0, 8'd0, 0, 2'd0, 8'd0, sec_pin, f0, f1);
    endtask

    task automatic rand_run(input int n, input bit f0, input bit f1);
        for (int i = 0; i < n; i++) begin
            bit cw;
            cw = ($urandom % 16) == 0;
            step(cw, 8'($urandom), 1'($urandom), 2'($urandom), 8'($urandom % 4),
                 1'($urandom), 2'($urandom), 8'($urandom % 4), 1'($urandom),
                 ($urandom % 8 == 0) ? ~f0 : f0, ($urandom % 8 == 0) ? ~f1 : f1);
        end
    endtask

    initial begin
        void'($urandom(32'h1209));
        // Unfused: protect writes do nothing, all granted
        do_reset(0, 0);
        idle(0, 0);
        step(1, 8'h40, 0, 2'd0, 8'd0, 1, 2'd2, 8'd0, 0, 0, 0);
        step(0, 8'h00, 1, 2'd0, 8'd0, 1, 2'd1, 8'd0, 0, 0, 0);
        check("R3 unfused write ignored", {7'd0, cpu_grant}, 8'd1);
        rand_run(300, 0, 0);

        // Mode-0 fuse blown
        do_reset(1, 0);
        idle(1, 0);
        check("R2 fuse captured", {7'd0, status[1]}, 8'd1);
        step(1, 8'hBF, 0, 2'd0, 8'd0, 1, 2'd2, 8'd0, 0, 1, 0);
        step(0, 8'h00, 1, 2'd0, 8'd5, 1, 2'd2, 8'd0, 0, 1, 0);
        check("R3 bit6 clear ignored", {7'd0, cpu_grant}, 8'd1);
        step(1, 8'h40, 0, 2'd0, 8'd0, 0, 2'd0, 8'd0, 0, 0, 0);
        step(0, 8'h00, 1, 2'd0, 8'd0, 1, 2'd2, 8'd0, 1, 0, 0);
        check("R4 guarded dbg read", {7'd0, dbg_deny}, 8'd1);
        check("R5 page0 write", {7'd0, cpu_deny}, 8'd1);
        check("R2 status after fuse drop", status, 8'h22);
        step(0, 8'h00, 1, 2'd1, 8'd0, 1, 2'd1, 8'd1, 0, 0, 0);
        check("R5 page1 erase", {7'd0, cpu_grant}, 8'd1);
        step(0, 8'h00, 1, 2'd3, 8'd0, 0, 2'd0, 8'd0, 0, 0, 0);
        check("R9 bulk clears ram", {7'd0, ram_clr}, 8'd1);
        idle(0, 0);
        check("R9 one pulse", {7'd0, ram_clr}, 8'd0);
        rand_run(300, 1, 0);

        // Reset leaves guarded mode
        do_reset(1, 0);
        idle(1, 0);
        step(0, 8'h00, 1, 2'd0, 8'd0, 0, 2'd0, 8'd0, 0, 1, 0);
        check("R3 reset clears guard", {7'd0, dbg_grant}, 8'd1);
        // Protect write on the capture edge
        do_reset(1, 0);
        step(1, 8'h40, 0, 2'd0, 8'd0, 0, 2'd0, 8'd0, 0, 1, 0);
        step(0, 8'h00, 1, 2'd2, 8'd3, 1, 2'd2, 8'd0, 0, 1, 0);
        check("R3 guard from capture edge", {7'd0, cpu_deny}, 8'd1);

        // Mode-1 fuse blown
        do_reset(0, 1);
        idle(0, 1);
        check("R7 dbg_en off", {7'd0, dbg_en}, 8'd0);
        step(0, 8'h00, 1, 2'd3, 8'd0, 0, 2'd0, 8'd0, 0, 0, 0);
        check("R7 bulk denied", {7'd0, dbg_deny}, 8'd1);
        rand_run(300, 1, 1);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule